// File: doc/BRIEF.md
# Program Counter Sequencer

This block produces the instruction fetch address for a small 8-bit controller core. The core has a 9-bit program counter and 512 words of program memory. Each cycle the core hands the block the 14-bit word it is executing. The core also supplies two strobes: one says that a skip instruction's condition held, and one says that the ALU is writing the program counter. A byte of ALU data comes with the write strobe. From these inputs the block picks the next address. It can step in sequence, jump short or long, call short or long, return, return with a literal, or take a direct write from the ALU. A two-entry return stack inside the block stores the return addresses.

The fetch and execute stages overlap by one cycle. The instruction that arrives in the cycle after any change of flow was fetched from the old path, so the block marks that slot with `squash`. The rest of the core treats the squashed word as a no-operation, and the block itself ignores it. As a result, every taken branch and every taken skip costs two cycles. For return-with-literal, the block passes the instruction's 8-bit immediate to the working register in the same cycle as the return.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_addr` is 9'h1FF (the last program word), `squash` is 1 and `w_load` is 0.
- R2: With no change of flow, `fetch_addr` advances by one per cycle and wraps from 9'h1FF to 9'h000.
- R3: A short jump (instr[13:9] = 5'b11001) or a long jump (instr[13:11] = 3'b101) loads `fetch_addr` with instr[8:0] on the next cycle and leaves the stack unchanged.
- R4: A short call (instr[13:8] = 6'b110000) loads `fetch_addr` with {1'b0, instr[7:0]} and pushes the current `fetch_addr`, which is the address after the call.
- R5: A long call (instr[13:11] = 3'b100) loads `fetch_addr` with instr[8:0] and pushes the current `fetch_addr`.
- R6: When `pc_wr` is high and the executing word is not a branch-class word, `fetch_addr` becomes {1'b0, `alu_data`}. A branch-class word takes priority over `pc_wr`, and `pc_wr` takes priority over `skip_hit`.
- R7: A return (instr = 14'h1004) or a return-with-literal (instr[13:8] = 6'b110001) loads `fetch_addr` with the top stack entry and pops the stack. For return-with-literal, `w_load` is 1 in that same cycle and `w_lit` equals instr[7:0].
- R8: The stack holds two entries. A third push discards the oldest entry. Pops beyond the stored entries keep returning the oldest entry that remains.
- R9: In the cycle after any change of flow (jump, call, return, ALU write or `skip_hit`), `squash` is 1 for exactly one cycle. A skip does not alter the sequential address.
- R10: In a squashed cycle, `instr`, `skip_hit` and `pc_wr` are ignored: `fetch_addr` advances by one, the stack does not move, `w_load` is 0 and `squash` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset (any reset cause) |
| instr | input | 14 | Instruction word being executed this cycle |
| skip_hit | input | 1 | A skip instruction's condition held this cycle |
| pc_wr | input | 1 | The ALU writes the program counter this cycle |
| alu_data | input | 8 | Data for an ALU write of the program counter |
| fetch_addr | output | 9 | Address of the word fetched this cycle |
| squash | output | 1 | The word executing this cycle is cancelled |
| w_load | output | 1 | Load `w_lit` into the working register |
| w_lit | output | 8 | Literal from a return-with-literal |

## Verification
A vector table runs through every change-of-flow kind in turn, and a plain sequential step follows each one. This separates the target selection for each form: full 9-bit against forced page-0 targets, and stack against instruction against ALU sources. It also shows that each squash slot lasts exactly one cycle. Squashed slots are loaded with jumps, ALU writes and skips, so an implementation that honours a cancelled word would be caught. Directed tests cover three nested calls followed by three returns to expose the overwrite and empty-pop behaviour of the stack. They also cover the wrap from the reset vector and the priority of a jump over an ALU write. The return-with-literal output is checked in both a live and a squashed cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PCS_ADDR_W  = 9;
  localparam int PCS_INSTR_W = 14;
  localparam int PCS_DATA_W  = 8;
  localparam int PCS_PAD_W   = PCS_ADDR_W - PCS_DATA_W;

  typedef logic [PCS_ADDR_W-1:0]  pc_t;
  typedef logic [PCS_INSTR_W-1:0] iw_t;
  typedef logic [PCS_DATA_W-1:0]  byte_t;

  typedef enum logic [2:0] {
    BR_NONE, BR_JMP, BR_CALL_S, BR_CALL_L, BR_RET, BR_RETLIT
  } br_kind_e;

  // branch-class decode of one instruction word
  function automatic br_kind_e br_decode(input iw_t iw);
    if (iw[13:11] == 3'b100)  return BR_CALL_L;
    if (iw[13:11] == 3'b101)  return BR_JMP;
    if (iw[13:9]  == 5'b11001) return BR_JMP;
    if (iw[13:8]  == 6'b110000) return BR_CALL_S;
    if (iw[13:8]  == 6'b110001) return BR_RETLIT;
    if (iw == 14'h1004)       return BR_RET;
    return BR_NONE;
  endfunction

  function automatic pc_t pc_incr(input pc_t p);
    return p + 1'b1;
  endfunction

  // page-zero target: upper bits forced low
  function automatic pc_t page0(input byte_t b);
    return {{PCS_PAD_W{1'b0}}, b};
  endfunction

  function automatic pc_t full_tgt(input iw_t iw);
    return iw[PCS_ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/pcs_stack.sv
module pcs_stack
  import pcs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  pc_t  push_val,
  output pc_t  top
);
  localparam int LAST = DEPTH - 1;

  pc_t ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push) begin
      ent[0] <= push_val;
      for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
    end else if (pop) begin
      // the deepest entry is kept, so an over-pop repeats it
      for (int i = 0; i < LAST; i++) ent[i] <= ent[i+1];
    end
  end

  assign top = ent[0];

  // R8: a push lands on top and shifts the old top down
  p_push_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top == $past(push_val)));
  p_push_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (ent[1] == $past(ent[0])));
  // R8: a pop exposes the next entry and keeps the deepest one
  p_pop_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (top == $past(ent[1])) && $stable(ent[LAST]));
  p_one_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
(
  input  pc_t      pc,
  input  iw_t      instr,
  input  logic     squash,
  input  logic     skip_hit,
  input  logic     pc_wr,
  input  byte_t    alu_data,
  input  pc_t      stk_top,
  output pc_t      pc_nxt,
  output logic     take,
  output logic     push_en,
  output logic     pop_en,
  output logic     short_tgt,
  output logic     w_load,
  output byte_t    w_lit
);
  br_kind_e kind;
  logic     wr_eff;
  logic     skip_eff;

  always_comb begin
    kind     = squash ? BR_NONE : br_decode(instr);
    wr_eff   = !squash && pc_wr && (kind == BR_NONE);
    skip_eff = !squash && skip_hit && (kind == BR_NONE) && !pc_wr;
    push_en  = 1'b0;
    pop_en   = 1'b0;
    unique case (kind)
      BR_JMP:             pc_nxt = full_tgt(instr);
      BR_CALL_S: begin    pc_nxt = page0(instr[7:0]); push_en = 1'b1; end
      BR_CALL_L: begin    pc_nxt = full_tgt(instr);   push_en = 1'b1; end
      BR_RET, BR_RETLIT: begin pc_nxt = stk_top;     pop_en  = 1'b1; end
      default:            pc_nxt = wr_eff ? page0(alu_data) : pc_incr(pc);
    endcase
    take      = (kind != BR_NONE) || wr_eff || skip_eff;
    short_tgt = (kind == BR_CALL_S) || wr_eff;
    w_load    = (kind == BR_RETLIT);
    w_lit     = instr[7:0];
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int STACK_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PCS_INSTR_W-1:0] instr,
  input  logic                   skip_hit,
  input  logic                   pc_wr,
  input  logic [PCS_DATA_W-1:0]  alu_data,
  output logic [PCS_ADDR_W-1:0]  fetch_addr,
  output logic                   squash,
  output logic                   w_load,
  output logic [PCS_DATA_W-1:0]  w_lit
);
  localparam pc_t RESET_VEC = '1;

  pc_t  pc_q, pc_nxt, stk_top;
  logic squash_q;
  logic take, push_en, pop_en, short_tgt;

  pcs_next u_next (
    .pc        (pc_q),
    .instr     (instr),
    .squash    (squash_q),
    .skip_hit  (skip_hit),
    .pc_wr     (pc_wr),
    .alu_data  (alu_data),
    .stk_top   (stk_top),
    .pc_nxt    (pc_nxt),
    .take      (take),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .short_tgt (short_tgt),
    .w_load    (w_load),
    .w_lit     (w_lit)
  );

  pcs_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_en),
    .pop      (pop_en),
    .push_val (pc_q),
    .top      (stk_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      squash_q <= 1'b1;      // nothing valid fetched yet
    end else begin
      pc_q     <= pc_nxt;
      squash_q <= take;
    end
  end

  assign fetch_addr = pc_q;
  assign squash     = squash_q;

  // R9: a change of flow cancels exactly the following slot
  p_take_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> squash);
  p_squash_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !squash);
  // R2: sequential stepping with wrap
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (fetch_addr == pc_t'($past(fetch_addr) + 1'b1)));
  // R4/R6: short call and ALU write land in page zero
  p_page0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_tgt |=> (fetch_addr[PCS_ADDR_W-1] == 1'b0));
  // R7: literal load only alongside a pop
  p_lit_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |-> pop_en);
  // R10: a cancelled word moves neither stack nor working register
  p_squash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (!push_en && !pop_en && !w_load));
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] instr = 14'h1000;
  logic        skip_hit = 1'b0;
  logic        pc_wr = 1'b0;
  logic [7:0]  alu_data = 8'h00;
  logic [8:0]  fetch_addr;
  logic        squash;
  logic        w_load;
  logic [7:0]  w_lit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .skip_hit(skip_hit),
    .pc_wr(pc_wr), .alu_data(alu_data), .fetch_addr(fetch_addr),
    .squash(squash), .w_load(w_load), .w_lit(w_lit)
  );

  localparam logic [13:0] NOP = 14'h1000;
  localparam logic [13:0] RET = 14'h1004;

  // {instr, skip, wr, alu, expected addr, expected squash}
  localparam int NV = 19;
  localparam logic [33:0] VEC [NV] = '{
    {14'h3255, 1'b0, 1'b0, 8'h00, 9'h000, 1'b0}, // R10 jump in squashed slot
    {NOP,      1'b0, 1'b0, 8'h00, 9'h001, 1'b0}, // R2
    {14'h3255, 1'b0, 1'b0, 8'h00, 9'h055, 1'b1}, // R3 short jump
    {NOP,      1'b0, 1'b0, 8'h00, 9'h056, 1'b0}, // R9
    {14'h29A0, 1'b0, 1'b0, 8'h00, 9'h1A0, 1'b1}, // R3 long jump
    {NOP,      1'b0, 1'b0, 8'h00, 9'h1A1, 1'b0},
    {14'h3042, 1'b0, 1'b0, 8'h00, 9'h042, 1'b1}, // R4 push 1A1
    {NOP,      1'b0, 1'b0, 8'h00, 9'h043, 1'b0},
    {14'h21F0, 1'b0, 1'b0, 8'h00, 9'h1F0, 1'b1}, // R5 push 043
    {NOP,      1'b0, 1'b0, 8'h00, 9'h1F1, 1'b0},
    {RET,      1'b0, 1'b0, 8'h00, 9'h043, 1'b1}, // R7 return
    {NOP,      1'b0, 1'b0, 8'h00, 9'h044, 1'b0},
    {14'h315A, 1'b0, 1'b0, 8'h00, 9'h1A1, 1'b1}, // R7 return with literal
    {NOP,      1'b0, 1'b0, 8'h00, 9'h1A2, 1'b0},
    {NOP,      1'b0, 1'b1, 8'hC3, 9'h0C3, 1'b1}, // R6 ALU write
    {NOP,      1'b0, 1'b0, 8'h00, 9'h0C4, 1'b0},
    {NOP,      1'b1, 1'b0, 8'h00, 9'h0C5, 1'b1}, // R9 skip
    {NOP,      1'b1, 1'b1, 8'h10, 9'h0C6, 1'b0}, // R10 strobes ignored
    {NOP,      1'b0, 1'b0, 8'h00, 9'h0C7, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] iw, input logic sk, input logic wr, input logic [7:0] d);
    instr = iw; skip_hit = sk; pc_wr = wr; alu_data = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input logic [13:0] iw, input logic sk, input logic wr, input logic [7:0] d);
    drive(iw, sk, wr, d);
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(NOP, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R1 addr in reset", 16'(fetch_addr), 16'h01FF);
    check("R1 squash in reset", 16'(squash), 16'h1);
    check("R1 w_load in reset", 16'(w_load), 16'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 addr after release", 16'(fetch_addr), 16'h01FF);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33:20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
      check($sformatf("vector %0d addr (R2-R10 table)", i), 16'(fetch_addr), 16'(VEC[i][9:1]));
      check($sformatf("vector %0d squash (R9 table)", i), 16'(squash), 16'(VEC[i][0]));
    end

    // R8: three nested calls, three returns
    do_reset();
    step(NOP, 1'b0, 1'b0, 8'h00);
    step(14'h3010, 1'b0, 1'b0, 8'h00); step(NOP, 1'b0, 1'b0, 8'h00); // push 000
    step(14'h3020, 1'b0, 1'b0, 8'h00); step(NOP, 1'b0, 1'b0, 8'h00); // push 011
    step(14'h3030, 1'b0, 1'b0, 8'h00); step(NOP, 1'b0, 1'b0, 8'h00); // push 021
    check("R5 after third call", 16'(fetch_addr), 16'h0031);
    step(RET, 1'b0, 1'b0, 8'h00);
    check("R8 first pop", 16'(fetch_addr), 16'h0021);
    step(NOP, 1'b0, 1'b0, 8'h00);
    step(RET, 1'b0, 1'b0, 8'h00);
    check("R8 second pop", 16'(fetch_addr), 16'h0011);
    step(NOP, 1'b0, 1'b0, 8'h00);
    step(RET, 1'b0, 1'b0, 8'h00);
    check("R8 over-pop repeats oldest", 16'(fetch_addr), 16'h0011);

    // R7: literal output in a live slot, R10: suppressed in a squashed slot
    step(NOP, 1'b0, 1'b0, 8'h00);
    drive(14'h31A7, 1'b0, 1'b0, 8'h00);
    #1;
    check("R7 w_load live", 16'(w_load), 16'h1);
    check("R7 w_lit live", 16'(w_lit), 16'h00A7);
    tick();
    check("R7 return target", 16'(fetch_addr), 16'h0011);
    drive(14'h31A7, 1'b0, 1'b0, 8'h00);
    #1;
    check("R10 w_load squashed", 16'(w_load), 16'h0);
    tick();
    check("R10 no pop in squashed slot", 16'(fetch_addr), 16'h0012);

    // R6: jump wins over ALU write
    step(14'h3255, 1'b0, 1'b1, 8'h77);
    check("R6 jump over pc_wr", 16'(fetch_addr), 16'h0055);

    // R2: wrap from last word
    step(NOP, 1'b0, 1'b0, 8'h00);
    step(14'h29FF, 1'b0, 1'b0, 8'h00);
    check("R3 long jump to top", 16'(fetch_addr), 16'h01FF);
    step(NOP, 1'b0, 1'b0, 8'h00);
    check("R2 wrap to zero", 16'(fetch_addr), 16'h0000);
    check("R9 squash lasts one cycle", 16'(squash), 16'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule